// File: doc/BRIEF.md
# I2C Channel-Select Controller

This block is an I2C target that owns a small control register. The register decides which of four downstream bus channels are joined to the upstream bus. The block samples the upstream SCL and SDA lines with the system clock and finds START and STOP conditions and clock edges. It answers only to its own 7-bit address and pulls SDA low through an open-drain enable. It drives four channel-enable outputs, which the surrounding pass-gate logic uses.

A write carries one data byte, and its low nibble becomes the new channel selection once the STOP condition arrives. A read returns one status byte that shows the asserted interrupt inputs and the current selection. Four active-low interrupt inputs, one per channel, are merged into a single active-low output. A power-on reset and an external active-low reset both clear the selection and return the protocol engine to idle. The external reset lets a host free a downstream bus that is stuck low.

Top module: `chsel_top`

## Requirements
- R1: The target address is 7 bits. Bits 6:2 are 11100 and bits 1:0 equal `strap_i`. When the address byte matches, the block acknowledges it by pulling SDA low during the ninth clock. Address bit 0 of that byte selects read (1) or write (0).
- R2: A write carries one data byte. Its bits 3:0 become the channel enables, with bit n enabling channel n. Bits 7:4 are ignored. Any combination is legal, from none to all four. The data byte is acknowledged.
- R3: After power-on reset, `chan_en_o` is 0000 and SDA is released.
- R4: While `ext_rst_ni` is low, `chan_en_o` is cleared and SDA is released, whatever the state of the bus. Once the reset is removed, the protocol engine accepts a fresh transfer.
- R5: `irq_no` is the AND of the four `irq_ni` inputs. It is low whenever any input is low.
- R6: A read returns one byte, MSB first. Bits 7:4 are the inverted `irq_ni` (1 means asserted), and bits 3:0 are the current channel enables. A 0 bit is sent by pulling SDA low.
- R7: A written value reaches `chan_en_o` only when STOP is detected. The outputs keep their old value during the transfer. A repeated START before STOP discards the written value.
- R8: The block ignores traffic to any other address. It gives no acknowledge, drives SDA in no cycle, and leaves the enables unchanged.
- R9: A START or STOP that arrives before all eight bits of the data byte aborts the transfer and leaves the enables unchanged.
- R10: SDA is only ever pulled low. This happens in acknowledge slots of the target and in data slots of a read, and nowhere else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External recovery reset, active low, asynchronous |
| strap_i | input | 2 | Address strap, low two bits of the target address |
| scl_i | input | 1 | Upstream serial clock, sampled |
| sda_i | input | 1 | Upstream serial data, sampled |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| irq_ni | input | 4 | Per-channel interrupt inputs, active low |
| irq_no | output | 1 | Merged interrupt output, active low |
| chan_en_o | output | 4 | Channel enables, one per downstream channel |

## Verification
A wrong protocol state shows up within one bit time. It appears either as a missing or extra low on SDA in the ninth clock, or as a read byte that goes wrong from its first bit. A wrong pending value or a wrong commit point stays hidden until STOP. At that moment `chan_en_o` either takes the wrong value or changes when it should not, so every transfer in the bench reads `chan_en_o` just before and just after its STOP. Failures of the abort and discard paths only show after the following STOP, which is why each of those cases is followed by a sample of the enables.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  localparam int unsigned CH_COUNT   = 4;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned STRAP_W    = 2;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned FIXED_W    = ADDR_W - STRAP_W;
  localparam logic [FIXED_W-1:0] ADDR_FIXED = 5'b11100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } tgt_st_e;

  // full 7-bit target address for a given strap value
  function automatic logic [ADDR_W-1:0] tgt_addr(input logic [STRAP_W-1:0] strap);
    return {ADDR_FIXED, strap};
  endfunction

  // true when the received address byte (addr + r/w) names this target
  function automatic logic addr_hit(input logic [BYTE_W-1:0] addr_byte,
                                    input logic [STRAP_W-1:0] strap);
    return addr_byte[BYTE_W-1:1] == tgt_addr(strap);
  endfunction

  // byte returned on a read: asserted interrupts above, enables below
  function automatic logic [BYTE_W-1:0] status_byte(input logic [CH_COUNT-1:0] irq_act,
                                                    input logic [CH_COUNT-1:0] en);
    return {irq_act, en};
  endfunction

endpackage

// File: rtl/chsel_line_sync.sv
module chsel_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;
  logic              scl_now;
  logic              sda_now;

  // idle bus is high, so the synchronizers reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_now    = scl_pipe[STAGES-1];
  assign sda_now    = sda_pipe[STAGES-1];
  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  // SDA moving while SCL stays high marks a bus condition
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/chsel_tgt_fsm.sv
module chsel_tgt_fsm
  import chsel_pkg::*;
#(
  parameter int unsigned NCH = CH_COUNT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_byte_i,
  output logic               sda_oe_o,
  output logic               commit_o,
  output logic [NCH-1:0]     commit_data_o,
  output logic [BYTE_W-1:0]  shreg_o,
  output logic               in_aack_o,
  output logic               in_slot_o,
  output logic               in_idle_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  tgt_st_e             st;
  logic [CNT_W-1:0]    bitcnt;
  logic [BYTE_W-1:0]   shreg;
  logic [BYTE_W-1:0]   rd_sh;
  logic                oe;
  logic                phase;
  logic                rw;
  logic                pend_v;
  logic [NCH-1:0]      pend_d;
  logic [BYTE_W-1:0]   shifted;

  assign shifted = {shreg[BYTE_W-2:0], sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      rd_sh  <= '0;
      oe     <= 1'b0;
      phase  <= 1'b0;
      rw     <= 1'b0;
      pend_v <= 1'b0;
      pend_d <= '0;
    end else if (start_i) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
      oe     <= 1'b0;
      phase  <= 1'b0;
      pend_v <= 1'b0;
    end else if (stop_i) begin
      st     <= ST_IDLE;
      oe     <= 1'b0;
      phase  <= 1'b0;
      pend_v <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: if (scl_rise_i) begin
          shreg  <= shifted;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) begin
            if (addr_hit(shifted, strap_i)) begin
              st <= ST_AACK;
              rw <= sda_i;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        ST_AACK: if (scl_fall_i) begin
          if (!phase) begin
            phase <= 1'b1;
            oe    <= 1'b1;
          end else begin
            phase  <= 1'b0;
            bitcnt <= '0;
            if (rw) begin
              st    <= ST_RDATA;
              rd_sh <= rd_byte_i;
              oe    <= ~rd_byte_i[BYTE_W-1];
            end else begin
              st <= ST_WDATA;
              oe <= 1'b0;
            end
          end
        end
        ST_WDATA: if (scl_rise_i) begin
          shreg  <= shifted;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) begin
            st     <= ST_WACK;
            pend_v <= 1'b1;
            pend_d <= shifted[NCH-1:0];
          end
        end
        ST_WACK: if (scl_fall_i) begin
          if (!phase) begin
            phase <= 1'b1;
            oe    <= 1'b1;
          end else begin
            phase <= 1'b0;
            oe    <= 1'b0;
            st    <= ST_SKIP;
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) st <= ST_RACK;
          end else if (scl_fall_i) begin
            rd_sh <= {rd_sh[BYTE_W-2:0], 1'b0};
            oe    <= ~rd_sh[BYTE_W-2];
          end
        end
        ST_RACK: if (scl_fall_i) begin
          oe <= 1'b0;
          st <= ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o      = oe;
  assign commit_o      = stop_i & pend_v;
  assign commit_data_o = pend_d;
  assign shreg_o       = shreg;
  assign in_aack_o     = (st == ST_AACK);
  assign in_slot_o     = (st == ST_AACK) | (st == ST_WACK) |
                         (st == ST_RDATA) | (st == ST_RACK);
  assign in_idle_o     = (st == ST_IDLE);

endmodule

// File: rtl/chsel_ctrl_reg.sv
module chsel_ctrl_reg #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           commit_i,
  input  logic [NCH-1:0] data_i,
  output logic [NCH-1:0] en_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_o <= '0;
    else if (commit_i) en_o <= data_i;
  end

endmodule

// File: rtl/chsel_irq_merge.sv
module chsel_irq_merge #(
  parameter int unsigned NCH = 4
) (
  input  logic [NCH-1:0] irq_ni,
  output logic [NCH-1:0] irq_act_o,
  output logic           irq_no
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign irq_act_o[g] = ~irq_ni[g];
  end

  // wired-AND of the active-low requests
  assign irq_no = ~(|irq_act_o);

endmodule

// File: rtl/chsel_top.sv
module chsel_top
  import chsel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                por_ni,
  input  logic                ext_rst_ni,
  input  logic [STRAP_W-1:0]  strap_i,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [CH_COUNT-1:0] irq_ni,
  output logic                irq_no,
  output logic [CH_COUNT-1:0] chan_en_o
);

  logic                rst_n;
  logic                sda_s;
  logic                scl_rise;
  logic                scl_fall;
  logic                start_evt;
  logic                stop_evt;
  logic                commit;
  logic [CH_COUNT-1:0] commit_data;
  logic [CH_COUNT-1:0] irq_act;
  logic [BYTE_W-1:0]   rd_byte;
  logic [BYTE_W-1:0]   rx_shreg;
  logic                in_aack;
  logic                in_slot;
  logic                in_idle;

  assign rst_n   = por_ni & ext_rst_ni;
  assign rd_byte = status_byte(irq_act, chan_en_o);

  chsel_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  chsel_tgt_fsm #(.NCH(CH_COUNT)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .sda_i         (sda_s),
    .scl_rise_i    (scl_rise),
    .scl_fall_i    (scl_fall),
    .start_i       (start_evt),
    .stop_i        (stop_evt),
    .strap_i       (strap_i),
    .rd_byte_i     (rd_byte),
    .sda_oe_o      (sda_oe_o),
    .commit_o      (commit),
    .commit_data_o (commit_data),
    .shreg_o       (rx_shreg),
    .in_aack_o     (in_aack),
    .in_slot_o     (in_slot),
    .in_idle_o     (in_idle)
  );

  chsel_ctrl_reg #(.NCH(CH_COUNT)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .commit_i (commit),
    .data_i   (commit_data),
    .en_o     (chan_en_o)
  );

  chsel_irq_merge #(.NCH(CH_COUNT)) u_irq (
    .irq_ni    (irq_ni),
    .irq_act_o (irq_act),
    .irq_no    (irq_no)
  );

endmodule

// File: rtl/chsel_checker.sv
module chsel_checker
  import chsel_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                por_n,
  input logic                ext_rst_n,
  input logic [STRAP_W-1:0]  strap,
  input logic [CH_COUNT-1:0] irq_n,
  input logic                irq_o_n,
  input logic [CH_COUNT-1:0] chan_en,
  input logic                sda_oe,
  input logic                start_evt,
  input logic                stop_evt,
  input logic [BYTE_W-1:0]   rx_shreg,
  input logic                in_aack,
  input logic                in_slot,
  input logic                in_idle
);

  assert_ack_own_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_aack |-> rx_shreg[BYTE_W-1:1] == {5'b11100, strap});

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  assert_ext_reset_clears_R4: assert property (@(posedge clk) disable iff (!por_n)
    !ext_rst_n |-> (chan_en == '0) && !sda_oe);

  assert_irq_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o_n == (&irq_n));

  assert_change_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> $past(stop_evt));

  assert_start_keeps_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> $stable(chan_en));

  assert_drive_in_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> in_slot);

endmodule

bind chsel_top chsel_checker u_chk (
  .clk       (clk_i),
  .rst_n     (rst_n),
  .por_n     (por_ni),
  .ext_rst_n (ext_rst_ni),
  .strap     (strap_i),
  .irq_n     (irq_ni),
  .irq_o_n   (irq_no),
  .chan_en   (chan_en_o),
  .sda_oe    (sda_oe_o),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .rx_shreg  (rx_shreg),
  .in_aack   (in_aack),
  .in_slot   (in_slot),
  .in_idle   (in_idle)
);

// File: tb/chsel_top_tb.sv
`timescale 1ns/1ps
module chsel_top_tb_top;

  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       por_n;
  logic       ext_n;
  logic [1:0] strap;
  logic       scl_m;
  logic       sda_m;
  logic [3:0] irq_n;
  logic       sda_oe;
  logic       irq_o;
  logic [3:0] chan;
  logic       sda_line;

  int n_chk  = 0;
  int n_fail = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] got_q[$];

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  chsel_top dut_i (
    .clk_i      (clk),
    .por_ni     (por_n),
    .ext_rst_ni (ext_n),
    .strap_i    (strap),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .irq_ni     (irq_n),
    .irq_no     (irq_o),
    .chan_en_o  (chan)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (got_q.size() != 0 && exp_q.size() != 0) begin
      logic [8:0] g;
      logic [8:0] e;
      string      t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, 32'(g), 32'(e));
    end
  end

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input string tag, input logic [8:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    wait_q(Q);
    scl_m = 1'b1; wait_q(2 * Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    b = sda_line; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  // sends a byte and records the ack bit seen on the line (0 = ack)
  task automatic send_byte(input logic [7:0] v);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    got_q.push_back({8'h00, a});
  endtask

  task automatic recv_byte(input logic mack);
    logic [7:0] v;
    logic       b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(mack);
    got_q.push_back({1'b0, v});
  endtask

  task automatic write_txn(input string tag, input logic [7:0] abyte,
                           input logic [7:0] data, input logic ack_exp);
    bus_start();
    expect_item({tag, " addr ack"}, {8'h00, ~ack_exp});
    send_byte(abyte);
    expect_item({tag, " data ack"}, {8'h00, ~ack_exp});
    send_byte(data);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [3:0] pats[5];
    por_n = 1'b0; ext_n = 1'b1; strap = 2'b10; irq_n = 4'hF;
    scl_m = 1'b1; sda_m = 1'b1;
    wait_q(5);
    chk("R3 enables in reset", 32'(chan), 32'h0);
    por_n = 1'b1;
    wait_q(5);
    chk("R3 enables after reset", 32'(chan), 32'h0);
    chk("R3 sda released", 32'(sda_oe), 32'h0);

    // R5 merged interrupt
    pats = '{4'hF, 4'hE, 4'h7, 4'h0, 4'hA};
    foreach (pats[i]) begin
      irq_n = pats[i];
      #1;
      chk("R5 irq merge", 32'(irq_o), 32'((pats[i] == 4'hF) ? 1 : 0));
    end
    irq_n = 4'hF;

    // R1 R2 R7: address 0x72 write, commit at STOP
    bus_start();
    expect_item("R1 addr ack", 9'h0);
    send_byte(8'hE4);
    expect_item("R2 data ack", 9'h0);
    send_byte(8'hA5);
    chk("R7 held before stop", 32'(chan), 32'h0);
    bus_stop();
    wait_q(5);
    chk("R2 low nibble applied", 32'(chan), 32'h5);

    // R8 foreign address
    write_txn("R8", 8'hE0, 8'h0F, 1'b0);
    wait_q(5);
    chk("R8 enables unchanged", 32'(chan), 32'h5);

    // R6 read status
    irq_n = 4'b1010;
    bus_start();
    expect_item("R1 read addr ack", 9'h0);
    send_byte(8'hE5);
    expect_item("R6 read byte", 9'h055);
    recv_byte(1'b1);
    bus_stop();
    irq_n = 4'hF;

    // R2 all channels, then upper bits ignored
    write_txn("R2 all", 8'hE4, 8'hFF, 1'b1);
    wait_q(5);
    chk("R2 all four", 32'(chan), 32'hF);
    write_txn("R2 none", 8'hE4, 8'hF0, 1'b1);
    wait_q(5);
    chk("R2 upper ignored", 32'(chan), 32'h0);

    // R7 repeated START discards pending write
    bus_start();
    expect_item("R7 addr ack", 9'h0);
    send_byte(8'hE4);
    expect_item("R7 data ack", 9'h0);
    send_byte(8'h03);
    bus_start();
    expect_item("R7 read addr ack", 9'h0);
    send_byte(8'hE5);
    expect_item("R7 discarded read", 9'h000);
    recv_byte(1'b1);
    bus_stop();
    wait_q(5);
    chk("R7 discarded", 32'(chan), 32'h0);

    // R9 STOP mid-byte
    bus_start();
    expect_item("R9 addr ack", 9'h0);
    send_byte(8'hE4);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    wait_q(5);
    chk("R9 stop mid byte", 32'(chan), 32'h0);

    // R9 START mid-byte, then a full write
    bus_start();
    expect_item("R9 addr ack 2", 9'h0);
    send_byte(8'hE4);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    wait_q(5);
    chk("R9 start mid byte keeps", 32'(chan), 32'h0);
    bus_start();
    expect_item("R9 restart addr ack", 9'h0);
    send_byte(8'hE4);
    expect_item("R9 restart data ack", 9'h0);
    send_byte(8'h06);
    bus_stop();
    wait_q(5);
    chk("R9 write after restart", 32'(chan), 32'h6);

    // R4 external reset in the middle of a transfer
    bus_start();
    expect_item("R4 addr ack", 9'h0);
    send_byte(8'hE4);
    ext_n = 1'b0;
    wait_q(5);
    chk("R4 enables cleared", 32'(chan), 32'h0);
    chk("R4 sda released", 32'(sda_oe), 32'h0);
    ext_n = 1'b1;
    wait_q(5);
    bus_stop();
    write_txn("R4 after reset", 8'hE4, 8'h09, 1'b1);
    wait_q(5);
    chk("R4 fresh transfer", 32'(chan), 32'h9);

    // R1 other strap
    strap = 2'b01;
    write_txn("R1 old addr", 8'hE4, 8'h01, 1'b0);
    wait_q(5);
    chk("R1 old addr ignored", 32'(chan), 32'h9);
    write_txn("R1 strap 01", 8'hE2, 8'h0C, 1'b1);
    wait_q(5);
    chk("R1 strap write", 32'(chan), 32'hC);

    irq_n = 4'b0111;
    bus_start();
    expect_item("R1 strap read ack", 9'h0);
    send_byte(8'hE3);
    expect_item("R6 read byte 2", 9'h08C);
    recv_byte(1'b1);
    bus_stop();
    wait_q(10);
    chk("R10 idle released", 32'(sda_oe), 32'h0);
    chk("R6 scoreboard drained", 32'(exp_q.size()), 32'h0);
    summary();
  end

endmodule